// File: doc/BRIEF.md
# PHY Lane Override Sequencer

This block forces the receive clock-recovery mode and, optionally, the transmit attenuation of one serial PHY lane after a link reset. It does this through a simple register access port: one request at a time, held until the access engine acknowledges it, with read data returned in the acknowledge cycle. Each lane's registers sit at a fixed stride above a set of base addresses, and all of those are parameters.

A start pulse captures a lane number, a clock-recovery mode and an attenuation code. The sequencer first polls the lane's receive status while it reports half-rate operation, up to a bounded number of reads. It then walks through a fixed series of read-modify-write accesses. The series arms the receive override, loads the mode field and pulses the recovery-loop reset bit. It then idles for a programmable settle time. Unless the attenuation code asks for it to be skipped, it finally arms the transmit override and loads the attenuation field. A separate disable pulse performs a single read-modify-write that drops the receive override. Either operation ends with a one-cycle done pulse.

Top module: `lane_ovr_seq`

## Requirements
- R1: While reset is held and after it is released with no command, `req_o` and `done_o` stay low.
- R2: `start_i` and `disable_i` are ignored while an operation is in progress. Lane, mode and attenuation are captured at the start pulse and used for the whole operation.
- R3: After start, the receive status register (RX_STS_BASE + lane*LANE_STRIDE, default 0x2002 + lane*0x100) is read repeatedly while bit 0 of the read data is 1. The polling stops after POLL_MAX reads even if bit 0 is still 1.
- R4: After polling, the receive status is read once more as value S. Five writes then go to the receive override register (RX_OVR_BASE + lane*LANE_STRIDE, default 0x2005 + lane*0x100). Their values, in order, are: A = S with bit 14 cleared; B = A with bit 14 set; C = B with bits 10:8 replaced by the mode; D = C with bit 11 set; E = D with bit 11 cleared.
- R5: After the acknowledge of the fifth receive write, no request is issued for WAIT_CYC cycles.
- R6: If attenuation bit 3 is 1, the transmit step is skipped entirely. Otherwise the transmit status (TX_STS_BASE + lane*LANE_STRIDE, default 0x2001 + lane*0x100) is read as T. Three writes then go to TX_OVR_BASE + lane*LANE_STRIDE (default 0x2004 + lane*0x100): T with bit 15 cleared; that value with bit 15 set; that value OR attenuation bits 2:0 placed at bits 12:10.
- R7: A disable pulse reads the receive status and writes it, with bit 14 cleared, to the receive override register. No other access is made.
- R8: `done_o` pulses for exactly one cycle per operation. It rises in the cycle after the acknowledge of the final access, or in the cycle after the settle time expires when the transmit step is skipped.
- R9: A request holds its address, direction and write data until acknowledged, and each acknowledge completes exactly one access, whatever the acknowledge latency.
- R10: When start and disable arrive in the same cycle, the start operation runs and the disable is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin the override operation |
| disable_i | input | 1 | Begin the override-release operation |
| lane_i | input | LANE_W | Lane selector |
| mode_i | input | MODE_W | Receive clock-recovery mode value |
| atten_i | input | ATTEN_W | Transmit attenuation; top bit requests skip |
| req_o | output | 1 | Register access request |
| we_o | output | 1 | 1 = write, 0 = read |
| addr_o | output | ADDR_W | Register address |
| wdata_o | output | DATA_W | Write data |
| ack_i | input | 1 | Access accepted; read data valid |
| rdata_i | input | DATA_W | Read data |
| done_o | output | 1 | Operation complete, one-cycle pulse |

## Verification
A wrong step index or a corrupted shadow value appears at the very next write as a wrong data word. A wrong state choice appears as an access to the wrong register class in the next request cycle. A miscounted poll or settle counter shows up as an extra or missing status read, or as a shifted gap before the transmit read. That is visible only after the full POLL_MAX or WAIT_CYC window. A lost or doubled acknowledge changes the access count and the done timing of the current operation.

// File: rtl/lane_ovr_pkg.sv
`timescale 1ns/1ps
package lane_ovr_pkg;

  typedef enum logic [1:0] {
    SEL_RX_STS,
    SEL_RX_OVR,
    SEL_TX_STS,
    SEL_TX_OVR
  } reg_sel_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_POLL,
    ST_RX_RD,
    ST_RX_WR,
    ST_WAIT,
    ST_TX_RD,
    ST_TX_WR,
    ST_DIS_RD,
    ST_DIS_WR
  } seq_state_e;

  localparam int HALF_RATE_BIT = 0;
  localparam int DPLL_MODE_LSB = 8;
  localparam int ATTEN_LSB     = 10;
  localparam int DPLL_RST_BIT  = 11;
  localparam int RX_OVR_BIT    = 14;
  localparam int TX_OVR_BIT    = 15;

  localparam int RX_WR_STEPS = 5;
  localparam int TX_WR_STEPS = 3;

endpackage

// File: rtl/lane_ovr_addr.sv
`timescale 1ns/1ps
module lane_ovr_addr
  import lane_ovr_pkg::*;
#(
  parameter int              ADDR_W      = 16,
  parameter int              LANE_W      = 2,
  parameter logic [ADDR_W-1:0] LANE_STRIDE = 16'h0100,
  parameter logic [ADDR_W-1:0] RX_STS_BASE = 16'h2002,
  parameter logic [ADDR_W-1:0] RX_OVR_BASE = 16'h2005,
  parameter logic [ADDR_W-1:0] TX_STS_BASE = 16'h2001,
  parameter logic [ADDR_W-1:0] TX_OVR_BASE = 16'h2004
) (
  input  reg_sel_e          sel_i,
  input  logic [LANE_W-1:0] lane_i,
  output logic [ADDR_W-1:0] addr_o
);

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] offs;

  always_comb begin
    unique case (sel_i)
      SEL_RX_STS: base = RX_STS_BASE;
      SEL_RX_OVR: base = RX_OVR_BASE;
      SEL_TX_STS: base = TX_STS_BASE;
      default:    base = TX_OVR_BASE;
    endcase
  end

  assign offs   = ADDR_W'(ADDR_W'(lane_i) * LANE_STRIDE);
  assign addr_o = base + offs;

endmodule

// File: rtl/lane_ovr_cnt.sv
`timescale 1ns/1ps
module lane_ovr_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/lane_ovr_seq.sv
`timescale 1ns/1ps
module lane_ovr_seq
  import lane_ovr_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter int                DATA_W      = 16,
  parameter int                LANE_W      = 2,
  parameter int                MODE_W      = 3,
  parameter int                ATTEN_W     = 4,
  parameter logic [ADDR_W-1:0] LANE_STRIDE = 16'h0100,
  parameter logic [ADDR_W-1:0] RX_STS_BASE = 16'h2002,
  parameter logic [ADDR_W-1:0] RX_OVR_BASE = 16'h2005,
  parameter logic [ADDR_W-1:0] TX_STS_BASE = 16'h2001,
  parameter logic [ADDR_W-1:0] TX_OVR_BASE = 16'h2004,
  parameter int                POLL_MAX    = 1000,
  parameter int                WAIT_CYC    = 1500000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               disable_i,
  input  logic [LANE_W-1:0]  lane_i,
  input  logic [MODE_W-1:0]  mode_i,
  input  logic [ATTEN_W-1:0] atten_i,
  output logic               req_o,
  output logic               we_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [DATA_W-1:0]  wdata_o,
  input  logic               ack_i,
  input  logic [DATA_W-1:0]  rdata_i,
  output logic               done_o
);

  localparam int PCW    = $clog2(POLL_MAX + 1);
  localparam int WCW    = $clog2(WAIT_CYC + 1);
  localparam int STEP_W = $clog2(RX_WR_STEPS);
  localparam logic [DATA_W-1:0] RX_OVR_M = DATA_W'(1) << RX_OVR_BIT;
  localparam logic [DATA_W-1:0] TX_OVR_M = DATA_W'(1) << TX_OVR_BIT;
  localparam logic [DATA_W-1:0] DRST_M   = DATA_W'(1) << DPLL_RST_BIT;

  seq_state_e         state_q;
  logic [STEP_W-1:0]  step_q;
  logic [DATA_W-1:0]  shadow_q;
  logic [LANE_W-1:0]  lane_q;
  logic [MODE_W-1:0]  mode_q;
  logic [ATTEN_W-1:0] atten_q;
  logic               done_q;
  logic               skip_tx;

  reg_sel_e sel;
  logic     poll_load, poll_dec, poll_zero;
  logic     wait_load, wait_dec, wait_zero;
  logic     half_rate, rx_last, tx_last;

  assign skip_tx   = atten_q[ATTEN_W-1];
  assign half_rate = rdata_i[HALF_RATE_BIT];
  assign rx_last   = (step_q == STEP_W'(RX_WR_STEPS - 1));
  assign tx_last   = (step_q == STEP_W'(TX_WR_STEPS - 1));

  assign poll_load = (state_q == ST_IDLE) && start_i;
  assign poll_dec  = (state_q == ST_POLL) && ack_i && half_rate;
  assign wait_load = (state_q == ST_RX_WR) && ack_i && rx_last;
  assign wait_dec  = (state_q == ST_WAIT);

  lane_ovr_cnt #(.W(PCW)) u_poll_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (poll_load),
    .load_val_i (PCW'(POLL_MAX - 1)),
    .dec_i      (poll_dec),
    .zero_o     (poll_zero)
  );

  lane_ovr_cnt #(.W(WCW)) u_wait_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wait_load),
    .load_val_i (WCW'(WAIT_CYC - 1)),
    .dec_i      (wait_dec),
    .zero_o     (wait_zero)
  );

  always_comb begin
    unique case (state_q)
      ST_RX_WR, ST_DIS_WR: sel = SEL_RX_OVR;
      ST_TX_RD:            sel = SEL_TX_STS;
      ST_TX_WR:            sel = SEL_TX_OVR;
      default:             sel = SEL_RX_STS;
    endcase
  end

  lane_ovr_addr #(
    .ADDR_W      (ADDR_W),
    .LANE_W      (LANE_W),
    .LANE_STRIDE (LANE_STRIDE),
    .RX_STS_BASE (RX_STS_BASE),
    .RX_OVR_BASE (RX_OVR_BASE),
    .TX_STS_BASE (TX_STS_BASE),
    .TX_OVR_BASE (TX_OVR_BASE)
  ) u_addr (
    .sel_i  (sel),
    .lane_i (lane_q),
    .addr_o (addr_o)
  );

  assign req_o   = (state_q != ST_IDLE) && (state_q != ST_WAIT);
  assign we_o    = (state_q == ST_RX_WR) || (state_q == ST_TX_WR) ||
                   (state_q == ST_DIS_WR);
  assign wdata_o = shadow_q;
  assign done_o  = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      step_q   <= '0;
      shadow_q <= '0;
      lane_q   <= '0;
      mode_q   <= '0;
      atten_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          // start outranks disable when both arrive together
          if (start_i) begin
            lane_q  <= lane_i;
            mode_q  <= mode_i;
            atten_q <= atten_i;
            state_q <= ST_POLL;
          end else if (disable_i) begin
            lane_q  <= lane_i;
            state_q <= ST_DIS_RD;
          end
        end
        ST_POLL: if (ack_i && !(half_rate && !poll_zero)) state_q <= ST_RX_RD;
        ST_RX_RD: if (ack_i) begin
          shadow_q <= rdata_i & ~RX_OVR_M;
          step_q   <= '0;
          state_q  <= ST_RX_WR;
        end
        ST_RX_WR: if (ack_i) begin
          step_q <= step_q + 1'b1;
          unique case (step_q)
            STEP_W'(0): shadow_q <= shadow_q | RX_OVR_M;
            STEP_W'(1): shadow_q[DPLL_MODE_LSB +: MODE_W] <= mode_q;
            STEP_W'(2): shadow_q <= shadow_q | DRST_M;
            STEP_W'(3): shadow_q <= shadow_q & ~DRST_M;
            default:    state_q  <= ST_WAIT;
          endcase
        end
        ST_WAIT: if (wait_zero) begin
          if (skip_tx) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            state_q <= ST_TX_RD;
          end
        end
        ST_TX_RD: if (ack_i) begin
          shadow_q <= rdata_i & ~TX_OVR_M;
          step_q   <= '0;
          state_q  <= ST_TX_WR;
        end
        ST_TX_WR: if (ack_i) begin
          step_q <= step_q + 1'b1;
          if (tx_last) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else if (step_q == '0) begin
            shadow_q <= shadow_q | TX_OVR_M;
          end else begin
            shadow_q[ATTEN_LSB +: ATTEN_W-1] <=
              shadow_q[ATTEN_LSB +: ATTEN_W-1] | atten_q[ATTEN_W-2:0];
          end
        end
        ST_DIS_RD: if (ack_i) begin
          shadow_q <= rdata_i & ~RX_OVR_M;
          state_q  <= ST_DIS_WR;
        end
        ST_DIS_WR: if (ack_i) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lane_ovr_chk.sv
`timescale 1ns/1ps
module lane_ovr_chk #(
  parameter int                ADDR_W      = 16,
  parameter int                DATA_W      = 16,
  parameter logic [ADDR_W-1:0] RX_STS_BASE = 16'h2002,
  parameter logic [ADDR_W-1:0] RX_OVR_BASE = 16'h2005,
  parameter logic [ADDR_W-1:0] TX_STS_BASE = 16'h2001,
  parameter logic [ADDR_W-1:0] TX_OVR_BASE = 16'h2004
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_o,
  input logic              we_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [DATA_W-1:0] wdata_o,
  input logic              ack_i,
  input logic              done_o
);

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o && $stable(addr_o) && $stable(we_o) && $stable(wdata_o)); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8

  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !req_o); // R8

  AST_WR_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && we_o |-> (addr_o[7:0] == RX_OVR_BASE[7:0]) || (addr_o[7:0] == TX_OVR_BASE[7:0])); // R4

  AST_RD_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !we_o |-> (addr_o[7:0] == RX_STS_BASE[7:0]) || (addr_o[7:0] == TX_STS_BASE[7:0])); // R3

  AST_RX_OVR_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && we_o && ack_i && (addr_o[7:0] == RX_OVR_BASE[7:0]) && wdata_o[14]
    |=> !req_o || (we_o && wdata_o[14])); // R4

endmodule

bind lane_ovr_seq lane_ovr_chk #(
  .ADDR_W      (ADDR_W),
  .DATA_W      (DATA_W),
  .RX_STS_BASE (RX_STS_BASE),
  .RX_OVR_BASE (RX_OVR_BASE),
  .TX_STS_BASE (TX_STS_BASE),
  .TX_OVR_BASE (TX_OVR_BASE)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_o   (req_o),
  .we_o    (we_o),
  .addr_o  (addr_o),
  .wdata_o (wdata_o),
  .ack_i   (ack_i),
  .done_o  (done_o)
);

// File: tb/lane_ovr_seq_test.sv
`timescale 1ns/1ps
module lane_ovr_seq_test;

  localparam int WAIT = 20;
  localparam int PMAX = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, dis = 1'b0;
  logic [1:0]  lane = '0;
  logic [2:0]  mode = '0;
  logic [3:0]  atten = '0;
  logic        req, we, ack = 1'b0, done;
  logic [15:0] addr, wdata, rdata = '0;

  lane_ovr_seq #(.POLL_MAX(PMAX), .WAIT_CYC(WAIT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .disable_i(dis),
    .lane_i(lane), .mode_i(mode), .atten_i(atten),
    .req_o(req), .we_o(we), .addr_o(addr), .wdata_o(wdata),
    .ack_i(ack), .rdata_i(rdata), .done_o(done)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  int n_tr = 0, done_cnt = 0, done_cyc = 0;
  int stall = 0, stall_cnt = 0, half_left = 0;
  logic [15:0] rx_sts = '0, tx_sts = '0;
  logic        log_we   [64];
  logic [15:0] log_addr [64];
  logic [15:0] log_data [64];
  int          log_cyc  [64];

  always @(posedge clk) cyc <= cyc + 1;

  // register access responder, acting on falling edges
  always @(negedge clk) begin
    if (ack) ack = 1'b0;
    else if (rst_n && req) begin
      if (stall_cnt < stall) stall_cnt++;
      else begin
        stall_cnt = 0;
        if (!we) begin
          if (addr[7:0] == 8'h02) begin
            if (half_left > 0) begin rdata = rx_sts | 16'h0001; half_left--; end
            else rdata = rx_sts & ~16'h0001;
          end else rdata = tx_sts;
        end
        if (n_tr < 64) begin
          log_we[n_tr] = we; log_addr[n_tr] = addr;
          log_data[n_tr] = we ? wdata : rdata; log_cyc[n_tr] = cyc;
        end
        n_tr++;
        ack = 1'b1;
      end
    end
    if (done) begin done_cnt++; done_cyc = cyc; end
  end

  always @(posedge clk) if (cyc > 150000) begin
    total++; bad++;
    $display("FAIL watchdog R8 act=hang exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(bit ok, string r, int act, int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s act=%0d exp=%0d", r, act, exp); end
  endtask

  task automatic exp_tr(int i, bit w, logic [15:0] a, logic [15:0] d, string r);
    total++;
    if (i >= n_tr || log_we[i] !== w || log_addr[i] !== a || (w && log_data[i] !== d)) begin
      bad++;
      $display("FAIL %s tr%0d act we=%0b addr=%h data=%h exp we=%0b addr=%h data=%h",
               r, i, log_we[i], log_addr[i], log_data[i], w, a, d);
    end
  endtask

  function automatic logic [15:0] rxs(logic [1:0] l); return 16'h2002 + {6'd0, l, 8'd0}; endfunction
  function automatic logic [15:0] rxo(logic [1:0] l); return 16'h2005 + {6'd0, l, 8'd0}; endfunction
  function automatic logic [15:0] txs(logic [1:0] l); return 16'h2001 + {6'd0, l, 8'd0}; endfunction
  function automatic logic [15:0] txo(logic [1:0] l); return 16'h2004 + {6'd0, l, 8'd0}; endfunction

  task automatic launch(bit s, bit d, logic [1:0] l, logic [2:0] m, logic [3:0] a);
    @(negedge clk);
    n_tr = 0; done_cnt = 0;
    start = s; dis = d; lane = l; mode = m; atten = a;
    @(negedge clk);
    start = 1'b0; dis = 1'b0;
  endtask

  task automatic finish_op();
    while (done_cnt == 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic check_full(logic [1:0] l, logic [2:0] m, logic [3:0] a, int npoll);
    int i = 0;
    int last_rx;
    logic [15:0] s, t;
    for (int p = 0; p < npoll; p++) begin exp_tr(i, 0, rxs(l), 16'h0, "R3"); i++; end
    exp_tr(i, 0, rxs(l), 16'h0, "R4"); s = log_data[i] & ~16'h4000; i++;
    exp_tr(i, 1, rxo(l), s, "R4"); i++;
    s = s | 16'h4000;                        exp_tr(i, 1, rxo(l), s, "R4"); i++;
    s = (s & ~16'h0700) | {5'd0, m, 8'd0};   exp_tr(i, 1, rxo(l), s, "R4"); i++;
    s = s | 16'h0800;                        exp_tr(i, 1, rxo(l), s, "R4"); i++;
    s = s & ~16'h0800;                       exp_tr(i, 1, rxo(l), s, "R4"); i++;
    last_rx = i - 1;
    if (!a[3]) begin
      chk(log_cyc[i] - log_cyc[last_rx] == WAIT + 1 + stall, "R5 wait gap",
          log_cyc[i] - log_cyc[last_rx], WAIT + 1 + stall);
      exp_tr(i, 0, txs(l), 16'h0, "R6"); t = log_data[i] & ~16'h8000; i++;
      exp_tr(i, 1, txo(l), t, "R6"); i++;
      t = t | 16'h8000;                      exp_tr(i, 1, txo(l), t, "R6"); i++;
      t = t | {3'd0, a[2:0], 10'd0};         exp_tr(i, 1, txo(l), t, "R6"); i++;
      chk(done_cyc - log_cyc[i-1] == 1, "R8 done timing", done_cyc - log_cyc[i-1], 1);
    end else begin
      chk(done_cyc - log_cyc[last_rx] == WAIT + 1, "R5 R6 skip done timing",
          done_cyc - log_cyc[last_rx], WAIT + 1);
    end
    chk(n_tr == i, "R9 access count", n_tr, i);
    chk(done_cnt == 1, "R8 done count", done_cnt, 1);
  endtask

  task automatic t_reset();
    chk(req === 1'b0, "R1 req in reset", req, 0);
    chk(done === 1'b0, "R1 done in reset", done, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(req === 1'b0 && n_tr == 0, "R1 req idle", n_tr, 0);
    chk(done === 1'b0 && done_cnt == 0, "R1 done idle", done_cnt, 0);
  endtask

  task automatic t_basic();
    rx_sts = 16'h4A5A; tx_sts = 16'h9C33; half_left = 0; stall = 0;
    launch(1, 0, 2'd1, 3'd3, 4'd5); finish_op();
    check_full(2'd1, 3'd3, 4'd5, 1);
  endtask

  task automatic t_poll();
    rx_sts = 16'h0F0F; tx_sts = 16'h0000; half_left = 2; stall = 0;
    launch(1, 0, 2'd2, 3'd6, 4'd7); finish_op();
    check_full(2'd2, 3'd6, 4'd7, 3);
  endtask

  task automatic t_poll_bound();
    rx_sts = 16'hFFFF; tx_sts = 16'hFFFF; half_left = 100; stall = 0;
    launch(1, 0, 2'd0, 3'd0, 4'd2); finish_op();
    check_full(2'd0, 3'd0, 4'd2, PMAX);
    half_left = 0;
  endtask

  task automatic t_skip();
    rx_sts = 16'h3100; tx_sts = 16'h1234; half_left = 0; stall = 0;
    launch(1, 0, 2'd3, 3'd1, 4'd9); finish_op();
    check_full(2'd3, 3'd1, 4'd9, 1);
  endtask

  task automatic t_disable();
    rx_sts = 16'hFFFF; half_left = 0; stall = 0;
    launch(0, 1, 2'd2, 3'd0, 4'd0); finish_op();
    exp_tr(0, 0, rxs(2'd2), 16'h0, "R7");
    exp_tr(1, 1, rxo(2'd2), log_data[0] & ~16'h4000, "R7");
    chk(n_tr == 2, "R7 access count", n_tr, 2);
    chk(done_cnt == 1 && done_cyc - log_cyc[1] == 1, "R7 R8 done", done_cyc - log_cyc[1], 1);
  endtask

  task automatic t_busy();
    rx_sts = 16'h0042; tx_sts = 16'h0400; half_left = 0; stall = 0;
    launch(1, 0, 2'd0, 3'd5, 4'd3);
    repeat (3) @(negedge clk);
    start = 1'b1; dis = 1'b1; lane = 2'd3; mode = 3'd1; atten = 4'd0;
    @(negedge clk); start = 1'b0; dis = 1'b0;
    repeat (WAIT) @(negedge clk);
    start = 1'b1; lane = 2'd2;
    @(negedge clk); start = 1'b0;
    finish_op();
    repeat (10) @(negedge clk);
    check_full(2'd0, 3'd5, 4'd3, 1); // R2
    chk(req === 1'b0, "R2 no second run", req, 0);
  endtask

  task automatic t_both();
    rx_sts = 16'h8001; tx_sts = 16'h7FFF; half_left = 0; stall = 0;
    launch(1, 1, 2'd1, 3'd7, 4'd1); finish_op();
    check_full(2'd1, 3'd7, 4'd1, 1); // R10
  endtask

  task automatic t_stall();
    rx_sts = 16'h4A5A; tx_sts = 16'h9C33; half_left = 1; stall = 2;
    launch(1, 0, 2'd3, 3'd2, 4'd6); finish_op();
    check_full(2'd3, 3'd2, 4'd6, 2); // R9
    stall = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_poll();
    t_poll_bound();
    t_skip();
    t_disable();
    t_busy();
    t_both();
    t_stall();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule